// File: doc/BRIEF.md
# Neural Network Sequencing Controller

This block is the control engine for a small fixed-point feed-forward network made of shared-input multiply-accumulate layers: three network inputs, a hidden layer of five neurons and a single output neuron. It does no arithmetic. It produces the per-layer strobes that tell the neurons to take their bias, to accumulate, and to drive their result. It also produces one address bus that every weight ROM and the input RAM read from.

External logic first fills the input RAM and then pulses `start`. The controller then runs a fixed schedule. One cycle preloads every neuron with its bias. The hidden layer then accumulates over one cycle per network input. The output neuron then accumulates over one cycle per hidden neuron. During that phase the hidden neurons drive the shared hidden bus one at a time, in index order, so the output neuron takes each hidden result as it is serialized off the bus. The run ends with a one-cycle `done` pulse, during which the output neuron drives its result.

Top module: `nnseq_ctrl`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, the controller returns to idle. On the following cycle every strobe, every bit of `hid_oe`, `done` and `addr` are all 0.
- R2: A `start` seen high in idle makes the next cycle a bias-load cycle. In that cycle `hid_load` and `out_load` are both 1, with no accumulate strobe and no output-enable.
- R3: The bias-load cycle is followed by N_IN cycles (3 by default) with `hid_acc` high. In these cycles `addr` runs 0, 1, 2, rising by one each cycle.
- R4: The hidden phase is followed by N_HID cycles (5 by default) with `out_acc` high. In these cycles `addr` runs 0 to 4, and `hid_oe` is one-hot with its set bit at index `addr`.
- R5: The cycle after the output phase has `done` high for exactly one cycle, with `out_oe` high in that same cycle only. The controller is idle in the cycle after that.
- R6: A `start` that arrives while a run is in progress (any cycle other than idle) has no effect: the schedule and its length are unchanged.
- R7: Outside the two accumulate phases, `addr` is 0 and `hid_oe` is all zero. In any cycle, at most one of {bias-load, hidden accumulate, output accumulate, done} is active.
- R8: With behavioural MAC neurons attached, the output neuron's value read during `done` equals its bias plus the sum over hidden neurons j of w_o[j] × h_j. Here h_j is bits 11:4 of hidden neuron j's 16-bit accumulator (bias plus the sum of input × weight).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run; honoured only in idle |
| addr | output | CW | Shared weight-ROM / input-RAM address |
| hid_load | output | 1 | Hidden layer bias load |
| hid_acc | output | 1 | Hidden layer accumulate enable |
| hid_oe | output | N_HID | Per hidden neuron output-enable, one-hot |
| out_load | output | 1 | Output neuron bias load |
| out_acc | output | 1 | Output neuron accumulate enable |
| out_oe | output | 1 | Output neuron output-enable |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the controller with its default shape of N_IN=3 and N_HID=5. The hidden and output phases therefore differ in length, and the address counter has to wrap at two different limits within one run. The bench also attaches behavioural MAC neurons to the strobes and address. With several input and weight patterns, this shows that each hidden result meets its matching output weight, and that a misplaced address or output-enable changes the final value.

// File: rtl/nnseq_pkg.sv
// Package: shared state type and helper for the network sequencing controller.
// Assumes: both layer sizes are at least 2.
package nnseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_BIAS = 3'd1,
        ST_HACC = 3'd2,
        ST_OACC = 3'd3,
        ST_DONE = 3'd4
    } nn_state_t;

    // Larger of two counts, used to size the shared address counter.
    function automatic int unsigned nn_max(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/nnseq_phase_cnt.sv
// Module: phase counter that doubles as the shared address.
// Counts while in an accumulate state. Flags the last beat of the phase and
// clears itself on that beat. Assumes the state input comes from nnseq_fsm.
module nnseq_phase_cnt
    import nnseq_pkg::*;
#(
    parameter int unsigned N_IN  = 3,
    parameter int unsigned N_HID = 5,
    parameter int unsigned CW    = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  nn_state_t       st,
    output logic [CW-1:0]   cnt,
    output logic            last
);

    localparam logic [CW-1:0] HID_END = CW'(N_IN - 1);
    localparam logic [CW-1:0] OUT_END = CW'(N_HID - 1);

    logic counting;

    // Decode the phase end from the current state and count.
    always_comb begin
        counting = (st == ST_HACC) || (st == ST_OACC);
        last     = ((st == ST_HACC) && (cnt == HID_END)) ||
                   ((st == ST_OACC) && (cnt == OUT_END));
    end

    // Advance the count inside a phase; clear it at the phase end or outside phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (counting && !last) begin
            cnt <= cnt + CW'(1);
        end else begin
            cnt <= '0;
        end
    end

endmodule

// File: rtl/nnseq_fsm.sv
// Module: state register of the sequencing controller.
// Walks idle -> bias -> hidden -> output -> done -> idle. Start matters only
// in idle. Phase ends come from nnseq_phase_cnt.
module nnseq_fsm
    import nnseq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      last,
    output nn_state_t st
);

    nn_state_t st_nx;

    // Choose the next state.
    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE: if (start) st_nx = ST_BIAS;
            ST_BIAS: st_nx = ST_HACC;
            ST_HACC: if (last) st_nx = ST_OACC;
            ST_OACC: if (last) st_nx = ST_DONE;
            ST_DONE: st_nx = ST_IDLE;
            default: st_nx = ST_IDLE;
        endcase
    end

    // Hold the state, forcing idle under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

endmodule

// File: rtl/nnseq_strobes.sv
// Module: strobe and address decoder.
// Pure Moore decode of state and count into the layer strobes, the one-hot
// hidden output-enables and the address bus. Address is zero outside phases.
module nnseq_strobes
    import nnseq_pkg::*;
#(
    parameter int unsigned N_HID = 5,
    parameter int unsigned CW    = 3
) (
    input  nn_state_t          st,
    input  logic [CW-1:0]      cnt,
    output logic [CW-1:0]      addr,
    output logic               hid_load,
    output logic               hid_acc,
    output logic [N_HID-1:0]   hid_oe,
    output logic               out_load,
    output logic               out_acc,
    output logic               out_oe,
    output logic               done
);

    logic in_phase;

    // Layer strobes and the address bus.
    always_comb begin
        in_phase = (st == ST_HACC) || (st == ST_OACC);
        hid_load = (st == ST_BIAS);
        out_load = (st == ST_BIAS);
        hid_acc  = (st == ST_HACC);
        out_acc  = (st == ST_OACC);
        out_oe   = (st == ST_DONE);
        done     = (st == ST_DONE);
        addr     = in_phase ? cnt : '0;
    end

    // One output-enable per hidden neuron, selected by the count.
    for (genvar j = 0; j < N_HID; j++) begin : g_oe
        assign hid_oe[j] = (st == ST_OACC) && (cnt == CW'(j));
    end

endmodule

// File: rtl/nnseq_ctrl.sv
// Module: top of the network sequencing controller.
// Joins the state register, the phase counter and the strobe decoder.
// Assumes the input RAM is full before start is raised, and that every
// neuron samples the strobes at the same rising edge.
module nnseq_ctrl
    import nnseq_pkg::*;
#(
    parameter int unsigned N_IN  = 3,
    parameter int unsigned N_HID = 5,
    localparam int unsigned CW   = $clog2(nn_max(N_IN, N_HID))
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic [CW-1:0]    addr,
    output logic             hid_load,
    output logic             hid_acc,
    output logic [N_HID-1:0] hid_oe,
    output logic             out_load,
    output logic             out_acc,
    output logic             out_oe,
    output logic             done
);

    nn_state_t     st;
    logic [CW-1:0] cnt;
    logic          last;

    nnseq_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .last  (last),
        .st    (st)
    );

    nnseq_phase_cnt #(.N_IN(N_IN), .N_HID(N_HID), .CW(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .st    (st),
        .cnt   (cnt),
        .last  (last)
    );

    nnseq_strobes #(.N_HID(N_HID), .CW(CW)) u_dec (
        .st       (st),
        .cnt      (cnt),
        .addr     (addr),
        .hid_load (hid_load),
        .hid_acc  (hid_acc),
        .hid_oe   (hid_oe),
        .out_load (out_load),
        .out_acc  (out_acc),
        .out_oe   (out_oe),
        .done     (done)
    );

endmodule

// File: rtl/nnseq_chk.sv
// Module: protocol checker bound to nnseq_ctrl.
// Watches the ports and the state register for the timing rules of the brief.
module nnseq_chk
    import nnseq_pkg::*;
#(
    parameter int unsigned N_IN  = 3,
    parameter int unsigned N_HID = 5,
    parameter int unsigned CW    = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input nn_state_t        st,
    input logic [CW-1:0]    addr,
    input logic             hid_load,
    input logic             hid_acc,
    input logic [N_HID-1:0] hid_oe,
    input logic             out_load,
    input logic             out_acc,
    input logic             out_oe,
    input logic             done
);

    // R1: reset leaves every output quiet on the next cycle.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!hid_load && !hid_acc && !out_load && !out_acc &&
                    !out_oe && !done && hid_oe == '0 && addr == '0));

    // R2: start in idle leads to both bias loads.
    a_r2_bias_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && start) |=> (hid_load && out_load && !hid_acc && !out_acc));

    // R3: hidden addresses begin at zero, step by one and stay in range.
    a_r3_hid_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hid_acc) |-> addr == '0);
    a_r3_hid_step: assert property (@(posedge clk) disable iff (!rst_n)
        (hid_acc && $past(hid_acc)) |-> addr == $past(addr) + CW'(1));
    a_r3_hid_range: assert property (@(posedge clk) disable iff (!rst_n)
        hid_acc |-> addr < CW'(N_IN));

    // R4: the hidden output-enable follows the address in the output phase.
    a_r4_oe_match: assert property (@(posedge clk) disable iff (!rst_n)
        out_acc |-> ($onehot0(hid_oe) && hid_oe[addr] && addr < CW'(N_HID)));
    a_r4_out_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_acc) |-> (addr == '0 && $past(hid_acc)));

    // R5: done lasts one cycle and coincides with the output enable.
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r5_done_oe: assert property (@(posedge clk) disable iff (!rst_n)
        out_oe == done);

    // R6: a busy controller ignores start and does not fall back to bias load.
    a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_IDLE && st != ST_DONE) |=> !hid_load);

    // R7: exclusive phases, quiet address outside the accumulate phases.
    a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hid_load, hid_acc, out_acc, done}));
    a_r7_addr_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!hid_acc && !out_acc) |-> (addr == '0 && hid_oe == '0));

endmodule

bind nnseq_ctrl nnseq_chk #(.N_IN(N_IN), .N_HID(N_HID), .CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .st       (st),
    .addr     (addr),
    .hid_load (hid_load),
    .hid_acc  (hid_acc),
    .hid_oe   (hid_oe),
    .out_load (out_load),
    .out_acc  (out_acc),
    .out_oe   (out_oe),
    .done     (done)
);

// File: tb/sim_nnseq_ctrl.sv
// Bench: directed scenarios on nnseq_ctrl, plus behavioural MAC neurons
// for the end-to-end result.
module sim_nnseq_ctrl;

    localparam int CLK_P = 10;
    localparam int NI = 3;
    localparam int NH = 5;
    localparam int CW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [CW-1:0] addr;
    logic hid_load, hid_acc, out_load, out_acc, out_oe, done;
    logic [NH-1:0] hid_oe;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #(CLK_P/2) clk = ~clk;

    nnseq_ctrl #(.N_IN(NI), .N_HID(NH)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .addr(addr),
        .hid_load(hid_load), .hid_acc(hid_acc), .hid_oe(hid_oe),
        .out_load(out_load), .out_acc(out_acc), .out_oe(out_oe), .done(done)
    );

    // Behavioural datapath: input RAM, weight ROMs, MAC neurons.
    logic signed [7:0]  in_ram [NI];
    logic signed [7:0]  wh [NH][NI];
    logic signed [15:0] bh [NH];
    logic signed [7:0]  wo [NH];
    logic signed [15:0] bo;
    logic signed [15:0] hacc [NH];
    logic signed [15:0] oacc;
    logic signed [7:0]  hbus;

    always_comb begin
        hbus = '0;
        for (int j = 0; j < NH; j++) if (hid_oe[j]) hbus = hacc[j][11:4];
    end

    always @(posedge clk) begin
        for (int j = 0; j < NH; j++) begin
            if (hid_load) hacc[j] <= bh[j];
            else if (hid_acc && addr < NI) hacc[j] <= hacc[j] + in_ram[addr] * wh[j][addr];
        end
        if (out_load) oacc <= bo;
        else if (out_acc) oacc <= oacc + hbus * wo[addr];
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int pack_out();
        return {hid_load, out_load, hid_acc, out_acc, out_oe, done, hid_oe, addr};
    endfunction

    // Expected packed outputs for cycle k after start (k=1 bias ... k=11 idle).
    function automatic int exp_out(input int k);
        logic hl, ol, ha, oa, oe, dn;
        logic [NH-1:0] ho;
        logic [CW-1:0] ad;
        hl = 0; ol = 0; ha = 0; oa = 0; oe = 0; dn = 0; ho = '0; ad = '0;
        if (k == 1) begin hl = 1; ol = 1; end
        else if (k >= 2 && k < 2 + NI) begin ha = 1; ad = CW'(k - 2); end
        else if (k >= 2 + NI && k < 2 + NI + NH) begin
            oa = 1; ad = CW'(k - 2 - NI); ho[k - 2 - NI] = 1'b1;
        end
        else if (k == 2 + NI + NH) begin oe = 1; dn = 1; end
        return {hl, ol, ha, oa, oe, dn, ho, ad};
    endfunction

    function automatic logic signed [15:0] model_result();
        logic signed [15:0] h;
        logic signed [15:0] o;
        logic signed [7:0]  hs;
        o = bo;
        for (int j = 0; j < NH; j++) begin
            h = bh[j];
            for (int i = 0; i < NI; i++) h = h + 16'(in_ram[i] * wh[j][i]);
            hs = h[11:4];
            o = o + 16'(hs * wo[j]);
        end
        return o;
    endfunction

    // Run one schedule, checking every cycle. busy_start holds start high while busy.
    task automatic run_sched(input string tag, input bit busy_start, input bit chk_data);
        @(negedge clk) start = 1'b1;
        @(negedge clk);
        for (int k = 1; k <= 11; k++) begin
            if (k <= 10) check($sformatf("%s k=%0d", tag, k), pack_out(), exp_out(k));
            else check($sformatf("R5 back to idle (%s)", tag), pack_out(), 0);
            if (k == 10 && chk_data) check("R8 network result", int'(oacc), int'(model_result()));
            start = busy_start && (k < 10);
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; start = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset quiet", pack_out(), 0);
        rst_n = 1'b1; start = 1'b0;
        @(negedge clk);
        check("R1 idle after reset", pack_out(), 0);
    endtask

    task automatic t_basic();
        run_sched("R2 R3 R4 R5 R7 sequence", 1'b0, 1'b0);
    endtask

    task automatic t_busy_start();
        run_sched("R6 start while busy", 1'b1, 1'b0);
    endtask

    task automatic load_pattern(input int seed);
        for (int i = 0; i < NI; i++) in_ram[i] = 8'(seed * 7 + i * 13 - 20);
        for (int j = 0; j < NH; j++) begin
            for (int i = 0; i < NI; i++) wh[j][i] = 8'(seed + j * 5 - i * 9 + 3);
            bh[j] = 16'(seed * 11 - j * 40);
            wo[j] = 8'(j * 6 - seed - 7);
        end
        bo = 16'(100 - seed * 3);
    endtask

    task automatic t_datapath();
        for (int p = 1; p <= 3; p++) begin
            load_pattern(p * 9);
            run_sched("R8 run", 1'b0, 1'b1);
        end
    endtask

    task automatic t_reset_mid();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset mid-run", pack_out(), 0);
        @(negedge clk);
        check("R1 stays idle", pack_out(), 0);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_busy_start();
        t_datapath();
        t_reset_mid();
        t_basic();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 20000);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule